// File: doc/BRIEF.md
# Retire Thread Arbiter

This block decides, for a multithreaded out-of-order core, which hardware thread may retire the instruction at the head of its reorder buffer in a given retire slot. For every thread it takes a status code, a head-ready bit, an empty bit and the sequence number of the head instruction. For every retire slot it returns a valid flag and a thread index. The retire logic consumes a grant by raising that slot's accept strobe. A slot may be asked for a grant several times in one cycle.

A two-bit policy input selects how the winner is chosen:
- **Round-robin** keeps an ordered list of thread indices. The first qualifying thread in the list wins. An accepted winner moves to the back of the list.
- **Oldest-first** grants the qualifying thread whose head instruction is oldest. It offers one grant per cycle.
- **Greedy** uses the same oldest pick as oldest-first, but offers it on every slot.

When the block is built for a single thread, the selection logic is left out. That thread is granted whenever its status permits, and the consumer checks head readiness itself. The block never reads or writes the reorder buffer.

Top module: `retire_thread_arbiter`

## Requirements
- R1: The status code is 3 bits per thread: 0 idle, 1 running, 2 trap wait, 3 fetch-trap wait, 4 flushing, 5 to 7 unused. Only codes 0, 1 and 3 let a thread qualify. A thread qualifies for round-robin only when its status permits and its head-ready bit is 1.
- R2: With policy 0 (round-robin), slot 0 grants the first qualifying thread found by scanning the order list from front to back.
- R3: When a round-robin grant is valid and its accept strobe is high at a clock edge, that thread leaves its place in the list and is appended at the back. The other threads keep their relative order.
- R4: After reset the order list holds the thread indices in ascending order, with 0 at the front.
- R5: The order list changes only through an accepted, valid round-robin grant. A strobe on a slot with no valid grant, or any strobe under policy 1, 2 or 3, leaves the list unchanged.
- R6: In round-robin mode, slot s sees the list as already updated by the grants accepted on slots below s in the same cycle.
- R7: With policy 1 (oldest-first; code 3 behaves the same way), a thread is a candidate when its status permits, its head is ready and its buffer is not empty. The candidate with the smallest head sequence number, compared unsigned, wins. A tie goes to the lowest thread index. Only slot 0 may be valid.
- R8: With policy 2 (greedy), every slot offers the same pick that R7 gives for slot 0.
- R9: When no thread qualifies under the active policy, every slot is invalid.
- R10: With one thread configured, every slot is valid exactly when that thread's status permits (R1), whatever its ready bit, empty bit and the policy. The index returned is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy | input | 2 | 0 round-robin, 1 oldest-first, 2 greedy, 3 as 1 |
| thr_state | input | NUM_THREADS*3 | Status code per thread, thread i in bits [3i+2:3i] |
| head_ready | input | NUM_THREADS | Head instruction of thread i may retire |
| rob_empty | input | NUM_THREADS | Reorder buffer of thread i holds nothing |
| head_seq | input | NUM_THREADS*SEQ_W | Head sequence number per thread |
| slot_take | input | NUM_SLOTS | Consumer accepts the grant of slot s |
| slot_vld | output | NUM_SLOTS | Slot s carries a grant |
| slot_tid | output | NUM_SLOTS*TID_W | Granted thread index per slot |

## Verification
The round-robin list is exercised in three ways:
- Full-eligibility streams show plain rotation.
- A lone eligible thread granted out of turn tells move-to-back apart from a rotating pointer: afterwards the order comes out as 0,1,3,2, not 3,0,1,2.
- Two-slot accept patterns, including a strobe on the upper slot only, show that the slots chain within a cycle.

The oldest pick is tried with:
- a sequence-number tie,
- an empty thread holding the smallest number,
- a not-ready thread.

These show the tie rule and the candidate filters. A round-robin probe taken after oldest-mode accepts shows that those accepts leave the list alone. Status codes that do not qualify, and a separate single-thread instance with its ready bit low, cover the status filter and the bypass.

// File: rtl/rta_pkg.sv
package rta_pkg;

   localparam int STATE_W = 3;

   typedef enum logic [STATE_W-1:0] {
      TS_IDLE       = 3'd0,
      TS_RUNNING    = 3'd1,
      TS_TRAP_WAIT  = 3'd2,
      TS_FTRAP_WAIT = 3'd3,
      TS_FLUSHING   = 3'd4
   } thr_state_e;

   localparam logic [1:0] POL_RR     = 2'd0;
   localparam logic [1:0] POL_OLDEST = 2'd1;
   localparam logic [1:0] POL_GREEDY = 2'd2;

   function automatic logic state_ok(input logic [STATE_W-1:0] s);
      return (s == TS_IDLE) || (s == TS_RUNNING) || (s == TS_FTRAP_WAIT);
   endfunction

endpackage

// File: rtl/rta_elig.sv
module rta_elig
   import rta_pkg::*;
#(
   parameter int NUM_THREADS = 4
) (
   input  logic [NUM_THREADS*STATE_W-1:0] thr_state,
   input  logic [NUM_THREADS-1:0]         head_ready,
   input  logic [NUM_THREADS-1:0]         rob_empty,
   output logic [NUM_THREADS-1:0]         rr_elig,
   output logic [NUM_THREADS-1:0]         old_elig
);
   for (genvar i = 0; i < NUM_THREADS; i++) begin : g_thr
      logic ok;
      assign ok          = state_ok(thr_state[i*STATE_W +: STATE_W]);
      assign rr_elig[i]  = ok & head_ready[i];
      assign old_elig[i] = ok & head_ready[i] & ~rob_empty[i];
   end
endmodule

// File: rtl/rta_oldest.sv
module rta_oldest #(
   parameter int NUM_THREADS = 4,
   parameter int SEQ_W       = 16,
   parameter int TID_W       = 2
) (
   input  logic [NUM_THREADS-1:0]       cand,
   input  logic [NUM_THREADS*SEQ_W-1:0] head_seq,
   output logic                         vld,
   output logic [TID_W-1:0]             tid
);
   logic [SEQ_W-1:0] best;

   // strict less-than keeps the lowest index on a tie
   always_comb begin
      vld  = 1'b0;
      tid  = '0;
      best = '0;
      for (int i = 0; i < NUM_THREADS; i++) begin
         if (cand[i] && (!vld || head_seq[i*SEQ_W +: SEQ_W] < best)) begin
            vld  = 1'b1;
            tid  = TID_W'(i);
            best = head_seq[i*SEQ_W +: SEQ_W];
         end
      end
   end
endmodule

// File: rtl/rta_rr_stage.sv
module rta_rr_stage #(
   parameter int NUM_THREADS = 4,
   parameter int TID_W       = 2
) (
   input  logic [NUM_THREADS*TID_W-1:0] list_in,
   input  logic [NUM_THREADS-1:0]       cand,
   input  logic                         take,
   output logic                         vld,
   output logic [TID_W-1:0]             tid,
   output logic [NUM_THREADS*TID_W-1:0] list_out
);
   logic [TID_W-1:0] ent;
   int               pos;

   always_comb begin
      vld = 1'b0;
      tid = '0;
      pos = 0;
      ent = '0;
      for (int p = 0; p < NUM_THREADS; p++) begin
         ent = list_in[p*TID_W +: TID_W];
         if (!vld && cand[ent]) begin
            vld = 1'b1;
            tid = ent;
            pos = p;
         end
      end
      list_out = list_in;
      if (take && vld) begin
         for (int p = 0; p < NUM_THREADS-1; p++) begin
            if (p >= pos)
               list_out[p*TID_W +: TID_W] = list_in[(p+1)*TID_W +: TID_W];
         end
         list_out[(NUM_THREADS-1)*TID_W +: TID_W] = tid;
      end
   end
endmodule

// File: rtl/retire_thread_arbiter.sv
module retire_thread_arbiter
   import rta_pkg::*;
#(
   parameter int NUM_THREADS = 4,
   parameter int SEQ_W       = 16,
   parameter int NUM_SLOTS   = 2,
   parameter int TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [1:0]                     policy,
   input  logic [NUM_THREADS*STATE_W-1:0] thr_state,
   input  logic [NUM_THREADS-1:0]         head_ready,
   input  logic [NUM_THREADS-1:0]         rob_empty,
   input  logic [NUM_THREADS*SEQ_W-1:0]   head_seq,
   input  logic [NUM_SLOTS-1:0]           slot_take,
   output logic [NUM_SLOTS-1:0]           slot_vld,
   output logic [NUM_SLOTS*TID_W-1:0]     slot_tid
);
   localparam int LIST_W = NUM_THREADS * TID_W;

   if (NUM_THREADS < 1) begin : g_bad_thr
      $error("NUM_THREADS must be at least 1");
   end
   if (NUM_SLOTS < 1) begin : g_bad_slot
      $error("NUM_SLOTS must be at least 1");
   end
   if (SEQ_W < 1) begin : g_bad_seq
      $error("SEQ_W must be at least 1");
   end

   if (NUM_THREADS == 1) begin : g_single
      logic ok;
      assign ok = state_ok(thr_state[STATE_W-1:0]);
      for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
         assign slot_vld[s]                = ok;
         assign slot_tid[s*TID_W +: TID_W] = '0;
      end
   end else begin : g_multi
      logic [NUM_THREADS-1:0] rr_elig, old_elig;
      logic                   old_vld;
      logic [TID_W-1:0]       old_tid;
      logic [LIST_W-1:0]      prio_q;
      logic [LIST_W-1:0]      chain [NUM_SLOTS+1];
      logic [NUM_SLOTS-1:0]   rr_vld;
      logic [TID_W-1:0]       rr_tid [NUM_SLOTS];
      logic                   is_rr;

      assign is_rr = (policy == POL_RR);

      rta_elig #(.NUM_THREADS(NUM_THREADS)) u_elig (
         .thr_state (thr_state),
         .head_ready(head_ready),
         .rob_empty (rob_empty),
         .rr_elig   (rr_elig),
         .old_elig  (old_elig)
      );

      rta_oldest #(.NUM_THREADS(NUM_THREADS), .SEQ_W(SEQ_W), .TID_W(TID_W)) u_oldest (
         .cand    (old_elig),
         .head_seq(head_seq),
         .vld     (old_vld),
         .tid     (old_tid)
      );

      assign chain[0] = prio_q;

      for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
         rta_rr_stage #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_stage (
            .list_in (chain[s]),
            .cand    (rr_elig),
            .take    (slot_take[s] & is_rr),
            .vld     (rr_vld[s]),
            .tid     (rr_tid[s]),
            .list_out(chain[s+1])
         );

         always_comb begin
            if (is_rr) begin
               slot_vld[s]                = rr_vld[s];
               slot_tid[s*TID_W +: TID_W] = rr_tid[s];
            end else if (policy == POL_GREEDY || s == 0) begin
               slot_vld[s]                = old_vld;
               slot_tid[s*TID_W +: TID_W] = old_tid;
            end else begin
               slot_vld[s]                = 1'b0;
               slot_tid[s*TID_W +: TID_W] = '0;
            end
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < NUM_THREADS; i++)
               prio_q[i*TID_W +: TID_W] <= TID_W'(i);
         end else begin
            prio_q <= chain[NUM_SLOTS];
         end
      end

      // ---------------- assertions ----------------
      logic [NUM_THREADS-1:0] held_mask;
      logic [TID_W-1:0]       tid0;
      logic [SEQ_W-1:0]       win_seq;
      logic                   only_take0;

      always_comb begin
         held_mask = '0;
         for (int p = 0; p < NUM_THREADS; p++)
            held_mask[prio_q[p*TID_W +: TID_W]] = 1'b1;
      end
      assign tid0       = slot_tid[TID_W-1:0];
      assign win_seq    = head_seq[tid0*SEQ_W +: SEQ_W];
      assign only_take0 = slot_take[0] && slot_vld[0] &&
                          ($countones(slot_take & slot_vld) == 1);

      // R2
      rr_grant_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (is_rr && slot_vld[0]) |-> rr_elig[tid0]);

      // R3
      rr_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (is_rr && only_take0) |=>
            (prio_q[(NUM_THREADS-1)*TID_W +: TID_W] == $past(tid0)));

      // R4
      list_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(held_mask) == NUM_THREADS);

      // R5
      list_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!is_rr) |=> $stable(prio_q));

      // R9
      none_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ((is_rr && rr_elig == '0) || (!is_rr && old_elig == '0)) |-> !slot_vld[0]);

      for (genvar i = 0; i < NUM_THREADS; i++) begin : g_age_chk
         // R7
         oldest_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!is_rr && slot_vld[0] && old_elig[i]) |->
               (win_seq <= head_seq[i*SEQ_W +: SEQ_W]));
      end
   end
endmodule

// File: tb/retire_thread_arbiter_bench.sv
module retire_thread_arbiter_bench;
   localparam int N  = 4;
   localparam int SW = 16;
   localparam int NS = 2;
   localparam int TW = 2;

   localparam logic [2:0] S_IDLE = 3'd0, S_RUN = 3'd1, S_TRAP = 3'd2,
                          S_FTRAP = 3'd3, S_FLUSH = 3'd4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        policy = 2'd0;
   logic [2:0]        st [N];
   logic [N-1:0]      ready = '0;
   logic [N-1:0]      empty = '1;
   logic [SW-1:0]     seq [N];
   logic [NS-1:0]     take = '0;
   logic [N*3-1:0]    st_flat;
   logic [N*SW-1:0]   seq_flat;
   logic [NS-1:0]     vld;
   logic [NS*TW-1:0]  tid;

   logic [2:0]        s1_state = S_IDLE;
   logic              s1_ready = 1'b0;
   logic              s1_empty = 1'b1;
   logic [NS-1:0]     s1_take = '0;
   logic [NS-1:0]     s1_vld;
   logic [NS-1:0]     s1_tid;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   always_comb begin
      for (int i = 0; i < N; i++) begin
         st_flat[i*3 +: 3]   = st[i];
         seq_flat[i*SW +: SW] = seq[i];
      end
   end

   retire_thread_arbiter #(.NUM_THREADS(N), .SEQ_W(SW), .NUM_SLOTS(NS)) u_retire_thread_arbiter (
      .clk(clk), .rst_n(rst_n), .policy(policy), .thr_state(st_flat),
      .head_ready(ready), .rob_empty(empty), .head_seq(seq_flat),
      .slot_take(take), .slot_vld(vld), .slot_tid(tid)
   );

   retire_thread_arbiter #(.NUM_THREADS(1), .SEQ_W(SW), .NUM_SLOTS(NS)) u_single (
      .clk(clk), .rst_n(rst_n), .policy(policy), .thr_state(s1_state),
      .head_ready(s1_ready), .rob_empty(s1_empty), .head_seq(16'd7),
      .slot_take(s1_take), .slot_vld(s1_vld), .slot_tid(s1_tid)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic set_all(input logic [2:0] s, input logic [N-1:0] r, input logic [N-1:0] e);
      for (int i = 0; i < N; i++) begin
         st[i]  = s;
         seq[i] = SW'(i);
      end
      ready = r;
      empty = e;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      take  = '0;
      @(posedge clk);
      @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   // drive strobes at negedge, check, commit at posedge, drop strobes
   task automatic look(input logic [NS-1:0] tk, input bit ev0, input int et0,
                       input bit ev1, input int et1, input string req);
      @(negedge clk);
      take = tk;
      #1;
      check({req, " slot0 valid"}, int'(vld[0]), int'(ev0));
      if (ev0) check({req, " slot0 tid"}, int'(tid[TW-1:0]), et0);
      check({req, " slot1 valid"}, int'(vld[1]), int'(ev1));
      if (ev1) check({req, " slot1 tid"}, int'(tid[2*TW-1:TW]), et1);
      @(posedge clk);
      #1 take = '0;
   endtask

   task automatic t_reset();
      do_reset();
      policy = 2'd0;
      set_all(S_IDLE, '0, '1);
      look(2'b00, 0, 0, 0, 0, "R9 reset none ready");
      set_all(S_IDLE, '1, '0);
      look(2'b00, 1, 0, 1, 0, "R4 reset order front");
   endtask

   task automatic t_rotate();
      do_reset();
      policy = 2'd0;
      set_all(S_RUN, '1, '0);
      for (int k = 0; k < 5; k++)
         look(2'b01, 1, k % N, 1, (k + 1) % N, "R2 R3 rotation");
   endtask

   task automatic t_move_back();
      do_reset();
      policy = 2'd0;
      set_all(S_RUN, 4'b0100, '0);
      look(2'b01, 1, 2, 1, 2, "R3 lone thread");
      set_all(S_RUN, '1, '0);
      look(2'b01, 1, 0, 1, 1, "R3 move-to-back a");
      look(2'b01, 1, 1, 1, 3, "R3 move-to-back b");
      look(2'b01, 1, 3, 1, 2, "R3 move-to-back c");
      look(2'b01, 1, 2, 1, 0, "R3 move-to-back d");
   endtask

   task automatic t_no_take();
      do_reset();
      policy = 2'd0;
      set_all(S_RUN, '1, '0);
      look(2'b00, 1, 0, 1, 0, "R5 no strobe a");
      look(2'b00, 1, 0, 1, 0, "R5 no strobe b");
      set_all(S_RUN, '0, '0);
      look(2'b11, 0, 0, 0, 0, "R5 strobe without grant");
      set_all(S_RUN, '1, '0);
      look(2'b00, 1, 0, 1, 0, "R5 list kept");
   endtask

   task automatic t_status();
      do_reset();
      policy = 2'd0;
      set_all(S_RUN, '1, '0);
      st[0] = S_TRAP; st[1] = S_FLUSH; st[2] = S_FTRAP; st[3] = 3'd7;
      look(2'b00, 1, 2, 1, 2, "R1 fetch-trap qualifies");
      st[0] = 3'd5; st[1] = 3'd6; st[2] = S_TRAP; st[3] = S_FLUSH;
      look(2'b00, 0, 0, 0, 0, "R1 R9 blocked states");
      st[0] = S_IDLE; st[1] = S_IDLE; ready = 4'b0010;
      look(2'b00, 1, 1, 1, 1, "R1 idle needs ready");
   endtask

   task automatic t_chain();
      do_reset();
      policy = 2'd0;
      set_all(S_RUN, '1, '0);
      look(2'b11, 1, 0, 1, 1, "R6 two slots a");
      look(2'b11, 1, 2, 1, 3, "R6 two slots b");
      look(2'b10, 1, 0, 1, 0, "R6 upper slot only");
      look(2'b00, 1, 1, 1, 1, "R6 upper slot commit");
   endtask

   task automatic t_oldest();
      do_reset();
      policy = 2'd1;
      set_all(S_RUN, '1, 4'b1000);
      seq[0] = 16'd40; seq[1] = 16'd10; seq[2] = 16'd10; seq[3] = 16'd5;
      look(2'b00, 1, 1, 0, 0, "R7 tie and empty");
      ready[1] = 1'b0;
      look(2'b11, 1, 2, 0, 0, "R7 not ready skipped");
      policy = 2'd3;
      look(2'b11, 1, 2, 0, 0, "R7 code 3");
      policy = 2'd0;
      ready = '1;
      look(2'b01, 1, 0, 1, 1, "R5 list after oldest accepts");
   endtask

   task automatic t_greedy();
      do_reset();
      policy = 2'd2;
      set_all(S_RUN, '1, '0);
      seq[0] = 16'd300; seq[1] = 16'd200; seq[2] = 16'd100; seq[3] = 16'd900;
      look(2'b11, 1, 2, 1, 2, "R8 both slots");
      set_all(S_RUN, '1, '1);
      look(2'b00, 0, 0, 0, 0, "R8 R9 all empty");
   endtask

   task automatic t_single();
      policy   = 2'd1;
      s1_state = S_RUN; s1_ready = 1'b0; s1_empty = 1'b1;
      @(negedge clk);
      check("R10 running unready slot0", int'(s1_vld[0]), 1);
      check("R10 running unready slot1", int'(s1_vld[1]), 1);
      check("R10 index", int'(s1_tid), 0);
      s1_state = S_TRAP;
      @(negedge clk);
      check("R10 trap wait", int'(s1_vld), 0);
      s1_state = S_FTRAP;
      policy   = 2'd0;
      @(negedge clk);
      check("R10 fetch-trap", int'(s1_vld), 3);
   endtask

   initial begin
      #(8 * 20000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      set_all(S_IDLE, '0, '1);
      t_reset();
      t_rotate();
      t_move_back();
      t_no_take();
      t_status();
      t_chain();
      t_oldest();
      t_greedy();
      t_single();
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule